// File: doc/BRIEF.md
# Layer-2 Header Rule Matcher

This block judges one received Ethernet frame header against a single programmed access rule. A frame is offered as its destination address, source address and EtherType together with a valid strobe. The rule is a set of static inputs: a 2-bit mode, a 2-bit enable field whose meaning depends on the mode, an address-select bit, a polarity bit, a 48-bit address and a 16-bit type value.

In header mode, the enable field chooses the fields that take part in the test. The choices are the address alone, the type alone, or both together. One address of the frame, picked by the select bit, is compared with the rule address. In address-pair mode, the frame's own source and destination addresses are compared with each other. The polarity bit decides whether equality or inequality counts as a hit. Every other encoding gives no match. The verdict is registered and appears, with its own valid strobe, one clock after the frame is offered.

Top module: `hdr_rule_matcher`

## Requirements
- R1: While `rst_n` is low, `resValid` and `resMatch` are both 0.
- R2: `resValid` is 1 in the cycle after an edge where `frmValid` was 1, and 0 otherwise. `resMatch` is 0 whenever `resValid` is 0.
- R3: With `ruleMode`=2'b01 and `ruleEnable`=2'b01, only the selected frame address is compared with `ruleMac`, and `frmType` has no effect on the result.
- R4: With `ruleMode`=2'b01 and `ruleEnable`=2'b10, only `frmType` is compared with `ruleType`, and neither frame address has any effect.
- R5: With `ruleMode`=2'b01 and `ruleEnable` equal to 2'b11 or 2'b00, both the selected address and the type must equal the rule for the fields to count as equal.
- R6: `ruleUseSrc`=0 selects `frmDstMac` for the address comparison, and `ruleUseSrc`=1 selects `frmSrcMac`.
- R7: `ruleMatchEq`=1 reports a match when the tested fields are equal. `ruleMatchEq`=0 reports a match when they are not equal.
- R8: With `ruleMode`=2'b10 and `ruleEnable`=2'b10, the test is `frmSrcMac` equal to `frmDstMac`, with polarity per R7. `ruleMac` and `ruleType` have no effect.
- R9: `ruleMode`=2'b00, `ruleMode`=2'b11, and `ruleMode`=2'b10 with `ruleEnable` of 2'b00 or 2'b11 always give `resMatch`=0, whatever the polarity.
- R10: All 48 address bits take part, including bits 47:40. A frame differing from the rule only in bit 47 or only in bit 0 is not equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frmValid | input | 1 | Frame header fields are valid this cycle |
| frmDstMac | input | 48 | Frame destination address |
| frmSrcMac | input | 48 | Frame source address |
| frmType | input | 16 | Frame EtherType |
| ruleMode | input | 2 | Rule mode: 01 header, 10 address pair, others inactive |
| ruleEnable | input | 2 | Field enable, interpreted by mode |
| ruleUseSrc | input | 1 | 0 compares destination address, 1 compares source address |
| ruleMatchEq | input | 1 | 1 matches on equal, 0 matches on not equal |
| ruleMac | input | 48 | Rule address, bit 47 most significant |
| ruleType | input | 16 | Rule type value |
| resValid | output | 1 | Verdict valid, one cycle after frmValid |
| resMatch | output | 1 | Match verdict |

## Verification
The capture of a new frame and the presentation of the previous frame's verdict can fall in the same cycle. The same applies to a field that must be ignored changing in a way that would flip a different mode's verdict. The bench provokes both:
- back-to-back valid strobes whose expected outcomes alternate;
- in address-only and type-only modes, the unused field set to a value that mismatches the rule.

A behavioural reference model predicts each cycle's verdict from the requirements and is compared on every clock, so a verdict that leaks between frames or picks up an ignored field is reported.

// File: rtl/hrm_pkg.sv
package hrm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_HDR  = 2'b01,
    MODE_PAIR = 2'b10,
    MODE_RSVD = 2'b11
  } ruleMode_e;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic active;   // rule encoding is usable
    logic chkAddr;  // selected address vs rule address
    logic chkType;  // frame type vs rule type
    logic chkPair;  // source vs destination of the frame
  } cmpCtrl_t;

endpackage

// File: rtl/hrm_ctrl.sv
module hrm_ctrl
  import hrm_pkg::*;
(
  input  logic [1:0] ruleMode,
  input  logic [1:0] ruleEnable,
  output cmpCtrl_t   ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (ruleMode)
      MODE_HDR: begin
        ctrl.active = 1'b1;
        unique case (ruleEnable)
          2'b01:   ctrl.chkAddr = 1'b1;
          2'b10:   ctrl.chkType = 1'b1;
          default: begin
            // 11: both fields; 00: both fields, action used as a count
            ctrl.chkAddr = 1'b1;
            ctrl.chkType = 1'b1;
          end
        endcase
      end
      MODE_PAIR: begin
        if (ruleEnable == 2'b10) begin
          ctrl.active  = 1'b1;
          ctrl.chkPair = 1'b1;
        end
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/hrm_datapath.sv
module hrm_datapath
  import hrm_pkg::*;
#(
  parameter int MAC_W  = 48,
  parameter int TYPE_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmpCtrl_t          ctrl,
  input  logic              frmValid,
  input  logic [MAC_W-1:0]  frmDstMac,
  input  logic [MAC_W-1:0]  frmSrcMac,
  input  logic [TYPE_W-1:0] frmType,
  input  logic              ruleUseSrc,
  input  logic              ruleMatchEq,
  input  logic [MAC_W-1:0]  ruleMac,
  input  logic [TYPE_W-1:0] ruleType,
  output logic              resValid,
  output logic              resMatch
);

  localparam int LANES = MAC_W / LANE_W;

  logic [LANES-1:0] dstLaneEq;
  logic [LANES-1:0] srcLaneEq;
  logic [LANES-1:0] pairLaneEq;

  // lane-wise equality; lane LANES-1 holds the top address byte
  for (genvar i = 0; i < LANES; i++) begin : gLane
    localparam int LO = i * LANE_W;
    assign dstLaneEq[i]  = frmDstMac[LO +: LANE_W] == ruleMac[LO +: LANE_W];
    assign srcLaneEq[i]  = frmSrcMac[LO +: LANE_W] == ruleMac[LO +: LANE_W];
    assign pairLaneEq[i] = frmSrcMac[LO +: LANE_W] == frmDstMac[LO +: LANE_W];
  end

  logic addrHit, typeHit, pairHit, fieldsEq, verdict;

  always_comb begin
    addrHit  = ruleUseSrc ? (&srcLaneEq) : (&dstLaneEq);
    typeHit  = frmType == ruleType;
    pairHit  = &pairLaneEq;
    fieldsEq = (addrHit | ~ctrl.chkAddr) &
               (typeHit | ~ctrl.chkType) &
               (pairHit | ~ctrl.chkPair);
    verdict  = ctrl.active & (ruleMatchEq ? fieldsEq : ~fieldsEq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      resMatch <= 1'b0;
    end else begin
      resValid <= frmValid;
      resMatch <= frmValid & verdict;
    end
  end

endmodule

// File: rtl/hdr_rule_matcher.sv
module hdr_rule_matcher
  import hrm_pkg::*;
#(
  parameter int MAC_W  = 48,
  parameter int TYPE_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frmValid,
  input  logic [MAC_W-1:0]  frmDstMac,
  input  logic [MAC_W-1:0]  frmSrcMac,
  input  logic [TYPE_W-1:0] frmType,
  input  logic [1:0]        ruleMode,
  input  logic [1:0]        ruleEnable,
  input  logic              ruleUseSrc,
  input  logic              ruleMatchEq,
  input  logic [MAC_W-1:0]  ruleMac,
  input  logic [TYPE_W-1:0] ruleType,
  output logic              resValid,
  output logic              resMatch
);

  cmpCtrl_t ctrl;

  hrm_ctrl u_ctrl (
    .ruleMode   (ruleMode),
    .ruleEnable (ruleEnable),
    .ctrl       (ctrl)
  );

  hrm_datapath #(.MAC_W(MAC_W), .TYPE_W(TYPE_W), .LANE_W(LANE_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .frmValid    (frmValid),
    .frmDstMac   (frmDstMac),
    .frmSrcMac   (frmSrcMac),
    .frmType     (frmType),
    .ruleUseSrc  (ruleUseSrc),
    .ruleMatchEq (ruleMatchEq),
    .ruleMac     (ruleMac),
    .ruleType    (ruleType),
    .resValid    (resValid),
    .resMatch    (resMatch)
  );

endmodule

// File: rtl/hrm_checker.sv
module hrm_checker #(
  parameter int MAC_W  = 48,
  parameter int TYPE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frmValid,
  input logic [MAC_W-1:0]  frmDstMac,
  input logic [MAC_W-1:0]  frmSrcMac,
  input logic [TYPE_W-1:0] frmType,
  input logic [1:0]        ruleMode,
  input logic [1:0]        ruleEnable,
  input logic              ruleUseSrc,
  input logic              ruleMatchEq,
  input logic [MAC_W-1:0]  ruleMac,
  input logic [TYPE_W-1:0] ruleType,
  input logic              resValid,
  input logic              resMatch
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!resValid && !resMatch);
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frmValid |=> resValid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frmValid |=> !resValid);

  assert_idle_no_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> !resMatch);

  assert_addr_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frmValid && ruleMode == 2'b01 && ruleEnable == 2'b01 && !ruleUseSrc &&
     frmDstMac == ruleMac) |=> (resMatch == $past(ruleMatchEq)));

  assert_type_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frmValid && ruleMode == 2'b01 && ruleEnable == 2'b10 && frmType != ruleType)
    |=> (resMatch == !$past(ruleMatchEq)));

  assert_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frmValid && ruleMode == 2'b10 && ruleEnable == 2'b10 && frmSrcMac == frmDstMac)
    |=> (resMatch == $past(ruleMatchEq)));

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frmValid && (ruleMode == 2'b00 || ruleMode == 2'b11 ||
                  (ruleMode == 2'b10 && ruleEnable != 2'b10))) |=> !resMatch);

endmodule

bind hdr_rule_matcher hrm_checker #(.MAC_W(MAC_W), .TYPE_W(TYPE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frmValid(frmValid), .frmDstMac(frmDstMac),
  .frmSrcMac(frmSrcMac), .frmType(frmType), .ruleMode(ruleMode),
  .ruleEnable(ruleEnable), .ruleUseSrc(ruleUseSrc), .ruleMatchEq(ruleMatchEq),
  .ruleMac(ruleMac), .ruleType(ruleType), .resValid(resValid), .resMatch(resMatch)
);

// File: tb/sim_hdr_rule_matcher.sv
`timescale 1ns/1ps
module sim_hdr_rule_matcher;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        frmValid;
  logic [47:0] frmDstMac, frmSrcMac, ruleMac;
  logic [15:0] frmType, ruleType;
  logic [1:0]  ruleMode, ruleEnable;
  logic        ruleUseSrc, ruleMatchEq;
  logic        resValid, resMatch;

  hdr_rule_matcher u0 (.*);

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  bit expValid = 0, expMatch = 0;
  string expTag = "R1";

  localparam logic [47:0] MA = 48'h0200_1122_3344;
  localparam logic [47:0] MB = 48'h0200_5566_7788;
  localparam logic [47:0] MTOP = MA ^ 48'h8000_0000_0000;
  localparam logic [47:0] MLOW = MA ^ 48'h1;
  localparam logic [15:0] TA = 16'h0800;
  localparam logic [15:0] TB = 16'h86DD;

  function automatic bit refMatch(bit [1:0] m, bit [1:0] e, bit us, bit eq,
                                  bit [47:0] d, bit [47:0] s, bit [15:0] t,
                                  bit [47:0] rm, bit [15:0] rt);
    bit [47:0] a;
    bit hit;
    a = us ? s : d;
    if (m == 2'b01) begin
      if (e == 2'b01)      hit = (a == rm);
      else if (e == 2'b10) hit = (t == rt);
      else                 hit = (a == rm) && (t == rt);
    end else if (m == 2'b10 && e == 2'b10) begin
      hit = (s == d);
    end else begin
      return 1'b0;
    end
    return eq ? hit : !hit;
  endfunction

  task automatic check(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(string tag, bit v, bit [1:0] m, bit [1:0] e, bit us, bit eq,
                      bit [47:0] d, bit [47:0] s, bit [15:0] t,
                      bit [47:0] rm, bit [15:0] rt);
    @(negedge clk);
    check(expTag, "resValid", resValid, expValid);
    check(expTag, "resMatch", resMatch, expMatch);
    frmValid = v; ruleMode = m; ruleEnable = e; ruleUseSrc = us; ruleMatchEq = eq;
    frmDstMac = d; frmSrcMac = s; frmType = t; ruleMac = rm; ruleType = rt;
    expValid = v;
    expMatch = v ? refMatch(m, e, us, eq, d, s, t, rm, rt) : 1'b0;
    expTag = tag;
  endtask

  function automatic string tagFor(bit v, bit [1:0] m, bit [1:0] e);
    if (!v) return "R2";
    if (m == 2'b01) return (e == 2'b01) ? "R3" : (e == 2'b10) ? "R4" : "R5";
    if (m == 2'b10 && e == 2'b10) return "R8";
    return "R9";
  endfunction

  function automatic bit [47:0] pickMac(int k);
    case (k % 4)
      0: return MA;
      1: return MB;
      2: return MLOW;
      default: return MTOP;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    frmValid = 0; ruleMode = 0; ruleEnable = 0; ruleUseSrc = 0; ruleMatchEq = 1;
    frmDstMac = MA; frmSrcMac = MA; frmType = TA; ruleMac = MA; ruleType = TA;
    repeat (3) @(negedge clk);
    frmValid = 1; ruleMode = 2'b01; ruleEnable = 2'b01;
    @(negedge clk);
    check("R1", "resValid in reset", resValid, 1'b0);
    check("R1", "resMatch in reset", resMatch, 1'b0);
    frmValid = 0;
    rst_n = 1'b1;

    // R3 address only: type mismatch ignored; top byte and low bit differences count (R10)
    step("R3", 1, 2'b01, 2'b01, 0, 1, MA, MB, TB, MA, TA);
    step("R10", 1, 2'b01, 2'b01, 0, 1, MTOP, MB, TA, MA, TA);
    step("R10", 1, 2'b01, 2'b01, 0, 1, MLOW, MB, TA, MA, TA);
    // R6 select: source equal, destination different
    step("R6", 1, 2'b01, 2'b01, 1, 1, MB, MA, TA, MA, TA);
    step("R6", 1, 2'b01, 2'b01, 0, 1, MB, MA, TA, MA, TA);
    // R4 type only: addresses mismatch ignored
    step("R4", 1, 2'b01, 2'b10, 0, 1, MB, MB, TA, MA, TA);
    step("R4", 1, 2'b01, 2'b10, 0, 1, MA, MA, TB, MA, TA);
    // R5 both fields, enable 11 and 00
    step("R5", 1, 2'b01, 2'b11, 0, 1, MA, MB, TA, MA, TA);
    step("R5", 1, 2'b01, 2'b11, 0, 1, MA, MB, TB, MA, TA);
    step("R5", 1, 2'b01, 2'b00, 1, 1, MB, MA, TA, MA, TA);
    step("R5", 1, 2'b01, 2'b00, 1, 1, MB, MLOW, TA, MA, TA);
    // R7 inverted polarity
    step("R7", 1, 2'b01, 2'b01, 0, 0, MA, MB, TA, MA, TA);
    step("R7", 1, 2'b01, 2'b01, 0, 0, MB, MB, TA, MA, TA);
    step("R7", 1, 2'b01, 2'b11, 0, 0, MA, MB, TB, MA, TA);
    // R8 pair compare, rule fields irrelevant
    step("R8", 1, 2'b10, 2'b10, 0, 1, MB, MB, TB, MA, TA);
    step("R8", 1, 2'b10, 2'b10, 0, 1, MA, MLOW, TA, MA, TA);
    step("R8", 1, 2'b10, 2'b10, 1, 0, MA, MTOP, TA, MA, TA);
    // R9 reserved encodings with both polarities
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 4; e++)
        if (!(m == 1 || (m == 2 && e == 2)))
          for (int p = 0; p < 2; p++)
            step("R9", 1, 2'(m), 2'(e), 0, 1'(p), MA, MA, TA, MA, TA);
    // R2 idle gap, then back-to-back alternating verdicts
    step("R2", 0, 2'b01, 2'b01, 0, 1, MA, MA, TA, MA, TA);
    step("R2", 0, 2'b01, 2'b01, 0, 0, MB, MA, TA, MA, TA);
    for (int i = 0; i < 8; i++)
      step("R2", 1, 2'b01, 2'b01, 0, 1, (i % 2) ? MB : MA, MB, TA, MA, TA);

    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      bit v;
      bit [1:0] m, e;
      v = ($urandom % 5) != 0;
      m = 2'($urandom);
      e = 2'($urandom);
      step(tagFor(v, m, e), v, m, e, 1'($urandom), 1'($urandom),
           pickMac($urandom), pickMac($urandom), ($urandom % 2) ? TA : TB,
           pickMac($urandom), ($urandom % 2) ? TA : TB);
    end
    step("R2", 0, 2'b00, 2'b00, 0, 1, MA, MA, TA, MA, TA);
    step("R2", 0, 2'b00, 2'b00, 0, 1, MA, MA, TA, MA, TA);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule